// File: doc/BRIEF.md
# Data Address Mark Searcher

This block watches the byte stream recovered from a floppy track right after an ID field has been read. Its job is to find where the following data field begins. Each incoming symbol is a byte plus a flag that marks a byte recorded with a special clock pattern. The search first crosses a gap region that may only be so long, then a run of zero bytes, and then the exact sync and mark sequence of the selected recording mode, FM or MFM. When a valid mark is seen, the block pulses a found output and states whether the mark denotes normal or deleted data. Any stray byte, and any sequence that does not fit the pattern, ends the search with a missing-mark pulse instead.

While it searches, the block drives preset and feed strobes for a separate CRC-16 unit, together with the byte to absorb. As a result, that unit already holds the checksum of the sync bytes and the mark when the data field starts. A controller raises `start` once per sector, picks the mode on the same cycle, and then presents symbols on `sym_valid` until one of the two result pulses appears.

Top module: `data_mark_finder`

## Requirements
- R1: After reset, and whenever no search is running, `busy`, `mark_found`, `mark_missing`, `mark_deleted`, `crc_preset` and `crc_feed` are all low. Symbols presented while idle produce no pulse.
- R2: A `start` seen while idle begins a search, with `busy` high from the next cycle. The mode is taken from `mfm_mode` on that cycle (1 = MFM, 0 = FM). A `start` given during a search is ignored, and the mode is not changed.
- R3: In MFM the gap byte is unflagged 0x4E and is skipped. An unflagged 0x00 moves the search into the zero run. Any other symbol ends the search with `mark_missing`.
- R4: In FM the gap byte is unflagged 0xFF and is skipped. An unflagged 0x00 moves the search into the zero run. Any other symbol ends the search with `mark_missing`.
- R5: A shared budget of 40 symbols (MFM) or 30 symbols (FM) is spent by every skipped gap byte and by every zero after the one that opened the run. When the budget reaches zero, MFM must next see three flagged 0xA1 bytes and then a mark. FM must next see one flagged mark byte.
- R6: In the zero run an unflagged 0x00 continues the run. In MFM, a flagged 0xA1 ends the run and counts as the first sync byte. In FM, a flagged byte in 0xF8..0xFB ends the run and completes the search. Any other symbol gives `mark_missing`.
- R7: In MFM, exactly three flagged 0xA1 bytes must come in a row. A different symbol in their place gives `mark_missing`.
- R8: The mark byte lies in 0xF8..0xFB. It must be unflagged in MFM and flagged in FM. Anything else at the mark position gives `mark_missing`.
- R9: With `mark_found`, `mark_deleted` is 0 for mark 0xFB and 1 for 0xF8, 0xF9 or 0xFA. It keeps its value until the next `mark_found`.
- R10: `crc_preset` pulses for every accepted zero-run byte and for the byte that exhausts the budget. `crc_feed` pulses, with `crc_byte` equal to the byte, for each sync byte and for the mark, and for no other byte.
- R11: Each search ends with exactly one one-cycle pulse of `mark_found` or `mark_missing`, one cycle after the deciding symbol, and `busy` is low from that cycle.
- R12: A cycle with `sym_valid` low leaves the search state, the budget and all pulses untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (honoured only while idle) |
| mfm_mode | input | 1 | 1 = MFM, 0 = FM, sampled with `start` |
| sym_valid | input | 1 | A symbol is present this cycle |
| sym_byte | input | 8 | Symbol data byte |
| sym_flag | input | 1 | Symbol was recorded with a special clock pattern |
| busy | output | 1 | Search in progress |
| mark_found | output | 1 | One-cycle pulse: valid data mark found |
| mark_missing | output | 1 | One-cycle pulse: search failed |
| mark_deleted | output | 1 | Class of the last mark found (1 = deleted data) |
| crc_preset | output | 1 | Preset the downstream CRC-16 |
| crc_feed | output | 1 | Absorb `crc_byte` into the CRC-16 |
| crc_byte | output | 8 | Byte to absorb |

## Verification
The bench builds the block with its default settings: a budget of 40 for MFM, 30 for FM, and three sync bytes. These values are small enough that a run of gap or zero bytes can be pushed exactly to the budget edge, and one symbol short of it. The bench can therefore tell an exhausted search, which must fall into the sync or mark stage, apart from one that still has budget left. The same build also reaches each error branch in both modes, every mark class, stalls in the middle of the sync sequence, and a restart attempt during a search.

// File: rtl/dam_pkg.sv
package dam_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_ZERO,
    ST_SYNC,
    ST_MARK
  } dam_state_e;

  localparam logic [7:0] MFM_GAP_BYTE  = 8'h4E;
  localparam logic [7:0] FM_GAP_BYTE   = 8'hFF;
  localparam logic [7:0] ZERO_BYTE     = 8'h00;
  localparam logic [7:0] MFM_SYNC_BYTE = 8'hA1;
  localparam logic [7:0] MARK_LOW      = 8'hF8;
  localparam logic [7:0] MARK_HIGH     = 8'hFB;
  localparam logic [7:0] MARK_NORMAL   = 8'hFB;

  typedef struct packed {
    logic gap;
    logic zero;
    logic sync;
    logic mark;
    logic deleted;
  } sym_class_t;

endpackage

// File: rtl/dam_rst_sync.sv
module dam_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dam_classify.sv
module dam_classify
  import dam_pkg::*;
(
  input  logic       mfm_sel,
  input  logic [7:0] sym_byte,
  input  logic       sym_flag,
  output sym_class_t cls
);
  logic in_mark_range;
  logic [7:0] gap_value;

  always_comb begin
    gap_value     = mfm_sel ? MFM_GAP_BYTE : FM_GAP_BYTE;
    in_mark_range = (sym_byte >= MARK_LOW) && (sym_byte <= MARK_HIGH);
    cls.gap       = !sym_flag && (sym_byte == gap_value);
    cls.zero      = !sym_flag && (sym_byte == ZERO_BYTE);
    cls.sync      = mfm_sel && sym_flag && (sym_byte == MFM_SYNC_BYTE);
    cls.mark      = in_mark_range && (mfm_sel ? !sym_flag : sym_flag);
    cls.deleted   = in_mark_range && (sym_byte != MARK_NORMAL);
  end
endmodule

// File: rtl/dam_budget.sv
module dam_budget #(
  parameter int MFM_BUDGET = 40,
  parameter int FM_BUDGET  = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic mfm_sel,
  input  logic dec,
  output logic last
);
  localparam int MAX_BUDGET = (MFM_BUDGET > FM_BUDGET) ? MFM_BUDGET : FM_BUDGET;
  localparam int CW = $clog2(MAX_BUDGET + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = mfm_sel ? CW'(MFM_BUDGET) : CW'(FM_BUDGET);
    else if (dec && (cnt_q != '0))
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load || dec)  cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CW'(1));

  p_budget_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_BUDGET));

  // R5: the sequencer never spends budget that is already gone
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> (cnt_q != '0));
endmodule

// File: rtl/dam_fsm.sv
module dam_fsm
  import dam_pkg::*;
#(
  parameter int SYNC_COUNT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mfm_mode,
  input  logic       sym_valid,
  input  sym_class_t cls,
  input  logic       bud_last,
  output logic       busy,
  output logic       mfm_q,
  output logic       bud_load,
  output logic       bud_dec,
  output logic       ev_found,
  output logic       ev_missing,
  output logic       ev_deleted,
  output logic       ev_preset,
  output logic       ev_feed
);
  localparam int SW = $clog2(SYNC_COUNT + 1);

  dam_state_e    state_q, state_d;
  logic [SW-1:0] sync_q, sync_d;
  logic          mode_d;
  logic          exhaust;

  always_comb begin
    state_d    = state_q;
    sync_d     = sync_q;
    mode_d     = mfm_q;
    bud_load   = 1'b0;
    bud_dec    = 1'b0;
    ev_found   = 1'b0;
    ev_missing = 1'b0;
    ev_deleted = 1'b0;
    ev_preset  = 1'b0;
    ev_feed    = 1'b0;
    exhaust    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_GAP;
          mode_d   = mfm_mode;
          bud_load = 1'b1;
        end
      end
      ST_GAP: begin
        if (sym_valid) begin
          if (cls.gap) begin
            bud_dec = 1'b1;
            exhaust = bud_last;
          end else if (cls.zero) begin
            state_d = ST_ZERO;
          end else begin
            ev_missing = 1'b1;
            state_d    = ST_IDLE;
          end
        end
      end
      ST_ZERO: begin
        if (sym_valid) begin
          if (cls.zero) begin
            ev_preset = 1'b1;
            bud_dec   = 1'b1;
            exhaust   = bud_last;
          end else if (mfm_q && cls.sync) begin
            ev_preset = 1'b1;
            ev_feed   = 1'b1;
            if (SYNC_COUNT > 1) begin
              state_d = ST_SYNC;
              sync_d  = SW'(SYNC_COUNT - 1);
            end else begin
              state_d = ST_MARK;
            end
          end else if (!mfm_q && cls.mark) begin
            ev_preset  = 1'b1;
            ev_feed    = 1'b1;
            ev_found   = 1'b1;
            ev_deleted = cls.deleted;
            state_d    = ST_IDLE;
          end else begin
            ev_missing = 1'b1;
            state_d    = ST_IDLE;
          end
        end
      end
      ST_SYNC: begin
        if (sym_valid) begin
          if (cls.sync) begin
            ev_feed = 1'b1;
            sync_d  = sync_q - SW'(1);
            if (sync_q == SW'(1)) state_d = ST_MARK;
          end else begin
            ev_missing = 1'b1;
            state_d    = ST_IDLE;
          end
        end
      end
      ST_MARK: begin
        if (sym_valid) begin
          if (cls.mark) begin
            ev_feed    = 1'b1;
            ev_found   = 1'b1;
            ev_deleted = cls.deleted;
          end else begin
            ev_missing = 1'b1;
          end
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (exhaust) begin
      ev_preset = 1'b1;
      if (mfm_q) begin
        state_d = ST_SYNC;
        sync_d  = SW'(SYNC_COUNT);
      end else begin
        state_d = ST_MARK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sync_q  <= '0;
      mfm_q   <= 1'b0;
    end else if (sym_valid || start) begin
      state_q <= state_d;
      sync_q  <= sync_d;
      mfm_q   <= mode_d;
    end
  end

  assign busy = (state_q != ST_IDLE);

  p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start) |=> (state_q == ST_GAP));

  p_mode_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(mfm_q));

  p_stall_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !sym_valid) |=> ($stable(state_q) && $stable(sync_q)));

  p_sync_mfm_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SYNC) |-> (mfm_q && sync_q != '0));
endmodule

// File: rtl/dam_result.sv
module dam_result (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_found,
  input  logic       ev_missing,
  input  logic       ev_deleted,
  input  logic       ev_preset,
  input  logic       ev_feed,
  input  logic [7:0] sym_byte,
  output logic       found_q,
  output logic       missing_q,
  output logic       deleted_q,
  output logic       preset_q,
  output logic       feed_q,
  output logic [7:0] crc_byte_q
);
  logic       deleted_d;
  logic [7:0] crc_byte_d;

  always_comb begin
    deleted_d  = ev_found ? ev_deleted : deleted_q;
    crc_byte_d = ev_feed  ? sym_byte   : crc_byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_q   <= 1'b0;
      missing_q <= 1'b0;
      preset_q  <= 1'b0;
      feed_q    <= 1'b0;
    end else begin
      found_q   <= ev_found;
      missing_q <= ev_missing;
      preset_q  <= ev_preset;
      feed_q    <= ev_feed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        deleted_q <= 1'b0;
    else if (ev_found) deleted_q <= deleted_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_byte_q <= 8'h00;
    else if (ev_feed) crc_byte_q <= crc_byte_d;
  end

  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(found_q && missing_q));

  p_deleted_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !found_q |-> $stable(deleted_q));
endmodule

// File: rtl/data_mark_finder.sv
module data_mark_finder
  import dam_pkg::*;
#(
  parameter int MFM_BUDGET = 40,
  parameter int FM_BUDGET  = 30,
  parameter int SYNC_COUNT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mfm_mode,
  input  logic       sym_valid,
  input  logic [7:0] sym_byte,
  input  logic       sym_flag,
  output logic       busy,
  output logic       mark_found,
  output logic       mark_missing,
  output logic       mark_deleted,
  output logic       crc_preset,
  output logic       crc_feed,
  output logic [7:0] crc_byte
);
  logic       rst_int_n;
  logic       mfm_q;
  sym_class_t cls;
  logic       bud_load, bud_dec, bud_last;
  logic       ev_found, ev_missing, ev_deleted, ev_preset, ev_feed;

  dam_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  dam_classify u_classify (
    .mfm_sel  (mfm_q),
    .sym_byte (sym_byte),
    .sym_flag (sym_flag),
    .cls      (cls)
  );

  dam_budget #(
    .MFM_BUDGET (MFM_BUDGET),
    .FM_BUDGET  (FM_BUDGET)
  ) u_budget (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (bud_load),
    .mfm_sel (mfm_mode),
    .dec     (bud_dec),
    .last    (bud_last)
  );

  dam_fsm #(
    .SYNC_COUNT (SYNC_COUNT)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .mfm_mode   (mfm_mode),
    .sym_valid  (sym_valid),
    .cls        (cls),
    .bud_last   (bud_last),
    .busy       (busy),
    .mfm_q      (mfm_q),
    .bud_load   (bud_load),
    .bud_dec    (bud_dec),
    .ev_found   (ev_found),
    .ev_missing (ev_missing),
    .ev_deleted (ev_deleted),
    .ev_preset  (ev_preset),
    .ev_feed    (ev_feed)
  );

  dam_result u_result (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ev_found   (ev_found),
    .ev_missing (ev_missing),
    .ev_deleted (ev_deleted),
    .ev_preset  (ev_preset),
    .ev_feed    (ev_feed),
    .sym_byte   (sym_byte),
    .found_q    (mark_found),
    .missing_q  (mark_missing),
    .deleted_q  (mark_deleted),
    .preset_q   (crc_preset),
    .feed_q     (crc_feed),
    .crc_byte_q (crc_byte)
  );

  p_result_idle_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mark_found || mark_missing) |-> !busy);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy && !start) |=> !(mark_found || mark_missing || crc_feed || crc_preset));

  p_feed_in_search_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    crc_feed |-> $past(busy));
endmodule

// File: tb/data_mark_finder_bench.sv
module data_mark_finder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       mfm_mode = 1'b0;
  logic       sym_valid = 1'b0;
  logic [7:0] sym_byte = 8'h00;
  logic       sym_flag = 1'b0;
  logic       busy, mark_found, mark_missing, mark_deleted;
  logic       crc_preset, crc_feed;
  logic [7:0] crc_byte;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  data_mark_finder u_data_mark_finder (
    .clk(clk), .rst_n(rst_n), .start(start), .mfm_mode(mfm_mode),
    .sym_valid(sym_valid), .sym_byte(sym_byte), .sym_flag(sym_flag),
    .busy(busy), .mark_found(mark_found), .mark_missing(mark_missing),
    .mark_deleted(mark_deleted), .crc_preset(crc_preset), .crc_feed(crc_feed),
    .crc_byte(crc_byte)
  );

  // row: req | start mode valid flag byte | busy found missing deleted preset feed
  function automatic logic [25:0] mk(int rq, int st, int md, int v, int fl, int b,
                                     int bz, int fd, int ms, int dl, int pr, int fe);
    return {rq[3:0], st[0], md[0], v[0], fl[0], b[7:0],
            bz[0], fd[0], ms[0], dl[0], pr[0], fe[0], 4'h0};
  endfunction

  localparam int NV = 60;
  localparam logic [25:0] VEC [NV] = '{
    // MFM normal mark: R2 R3 R10 R6 R7 R9, then idle symbol R1
    mk(2,1,1,0,0,8'h00, 1,0,0,0,0,0),
    mk(3,0,0,1,0,8'h4E, 1,0,0,0,0,0),
    mk(3,0,0,1,0,8'h4E, 1,0,0,0,0,0),
    mk(3,0,0,1,0,8'h00, 1,0,0,0,0,0),
    mk(10,0,0,1,0,8'h00, 1,0,0,0,1,0),
    mk(10,0,0,1,0,8'h00, 1,0,0,0,1,0),
    mk(6,0,0,1,1,8'hA1, 1,0,0,0,1,1),
    mk(7,0,0,1,1,8'hA1, 1,0,0,0,0,1),
    mk(7,0,0,1,1,8'hA1, 1,0,0,0,0,1),
    mk(9,0,0,1,0,8'hFB, 0,1,0,0,0,1),
    mk(1,0,0,1,0,8'h00, 0,0,0,0,0,0),
    // MFM deleted F8, pulse ends R11
    mk(2,1,1,0,0,8'h00, 1,0,0,0,0,0),
    mk(3,0,0,1,0,8'h00, 1,0,0,0,0,0),
    mk(6,0,0,1,1,8'hA1, 1,0,0,0,1,1),
    mk(7,0,0,1,1,8'hA1, 1,0,0,0,0,1),
    mk(7,0,0,1,1,8'hA1, 1,0,0,0,0,1),
    mk(9,0,0,1,0,8'hF8, 0,1,0,1,0,1),
    mk(11,0,0,0,0,8'h00, 0,0,0,1,0,0),
    // FM normal: R4 R6
    mk(2,1,0,0,0,8'h00, 1,0,0,1,0,0),
    mk(4,0,0,1,0,8'hFF, 1,0,0,1,0,0),
    mk(4,0,0,1,0,8'h00, 1,0,0,1,0,0),
    mk(10,0,0,1,0,8'h00, 1,0,0,1,1,0),
    mk(6,0,0,1,1,8'hFB, 0,1,0,0,1,1),
    // FM deleted FA
    mk(2,1,0,0,0,8'h00, 1,0,0,0,0,0),
    mk(4,0,0,1,0,8'h00, 1,0,0,0,0,0),
    mk(9,0,0,1,1,8'hFA, 0,1,0,1,1,1),
    // MFM stray gap byte R3
    mk(2,1,1,0,0,8'h00, 1,0,0,1,0,0),
    mk(3,0,0,1,0,8'h4E, 1,0,0,1,0,0),
    mk(3,0,0,1,0,8'hFF, 0,0,1,1,0,0),
    // FM flagged gap byte R4
    mk(2,1,0,0,0,8'h00, 1,0,0,1,0,0),
    mk(4,0,0,1,1,8'hFF, 0,0,1,1,0,0),
    // MFM unflagged A1 in zero run R6
    mk(2,1,1,0,0,8'h00, 1,0,0,1,0,0),
    mk(3,0,0,1,0,8'h00, 1,0,0,1,0,0),
    mk(6,0,0,1,0,8'hA1, 0,0,1,1,0,0),
    // MFM only two sync bytes R7
    mk(2,1,1,0,0,8'h00, 1,0,0,1,0,0),
    mk(3,0,0,1,0,8'h00, 1,0,0,1,0,0),
    mk(6,0,0,1,1,8'hA1, 1,0,0,1,1,1),
    mk(7,0,0,1,1,8'hA1, 1,0,0,1,0,1),
    mk(7,0,0,1,0,8'hFB, 0,0,1,1,0,0),
    // MFM flagged mark R8
    mk(2,1,1,0,0,8'h00, 1,0,0,1,0,0),
    mk(3,0,0,1,0,8'h00, 1,0,0,1,0,0),
    mk(6,0,0,1,1,8'hA1, 1,0,0,1,1,1),
    mk(7,0,0,1,1,8'hA1, 1,0,0,1,0,1),
    mk(7,0,0,1,1,8'hA1, 1,0,0,1,0,1),
    mk(8,0,0,1,1,8'hFB, 0,0,1,1,0,0),
    // FM unflagged mark R8
    mk(2,1,0,0,0,8'h00, 1,0,0,1,0,0),
    mk(4,0,0,1,0,8'h00, 1,0,0,1,0,0),
    mk(8,0,0,1,0,8'hFB, 0,0,1,1,0,0),
    // FM out-of-range flagged F7 R8
    mk(2,1,0,0,0,8'h00, 1,0,0,1,0,0),
    mk(4,0,0,1,0,8'h00, 1,0,0,1,0,0),
    mk(8,0,0,1,1,8'hF7, 0,0,1,1,0,0),
    // MFM with stalls R12, deleted F9
    mk(2,1,1,0,0,8'h00, 1,0,0,1,0,0),
    mk(12,0,0,0,0,8'h4E, 1,0,0,1,0,0),
    mk(3,0,0,1,0,8'h00, 1,0,0,1,0,0),
    mk(12,0,0,0,1,8'hFF, 1,0,0,1,0,0),
    mk(6,0,0,1,1,8'hA1, 1,0,0,1,1,1),
    mk(7,0,0,1,1,8'hA1, 1,0,0,1,0,1),
    mk(12,0,0,0,1,8'hA1, 1,0,0,1,0,0),
    mk(7,0,0,1,1,8'hA1, 1,0,0,1,0,1),
    mk(9,0,0,1,0,8'hF9, 0,1,0,1,0,1)
  };

  task automatic chk1(input string rq, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", rq, what, act, exp);
    end
  endtask

  task automatic chk8(input string rq, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input logic st, input logic md, input logic v, input logic fl, input logic [7:0] b);
    @(negedge clk);
    start = st; mfm_mode = md; sym_valid = v; sym_flag = fl; sym_byte = b;
    @(posedge clk);
    #1;
  endtask

  task automatic go(input logic md);
    drive(1'b1, md, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic send(input logic fl, input logic [7:0] b);
    drive(1'b0, 1'b0, 1'b1, fl, b);
  endtask

  task automatic outs(input string rq, input logic bz, input logic fd, input logic ms,
                      input logic dl, input logic pr, input logic fe);
    chk1(rq, "busy", busy, bz);
    chk1(rq, "found", mark_found, fd);
    chk1(rq, "missing", mark_missing, ms);
    chk1(rq, "deleted", mark_deleted, dl);
    chk1(rq, "preset", crc_preset, pr);
    chk1(rq, "feed", crc_feed, fe);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    outs("R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] r;
      string rq;
      r = VEC[i];
      rq = $sformatf("R%0d row%0d", r[25:22], i);
      drive(r[21], r[20], r[19], r[18], r[17:10]);
      outs(rq, r[9], r[8], r[7], r[6], r[5], r[4]);
      if (r[4]) chk8(rq, "crc_byte", crc_byte, r[17:10]);
    end

    // R5: MFM gap budget exhausted by the 40th gap byte, then three syncs
    go(1'b1);
    for (int i = 0; i < 39; i++) send(1'b0, 8'h4E);
    outs("R5 mfm gap 39", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    send(1'b0, 8'h4E);
    outs("R5 mfm gap 40", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) send(1'b1, 8'hA1);
    outs("R5 mfm sync", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    send(1'b0, 8'hFB);
    outs("R5 mfm gap exhaust mark", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);

    // R5: 39 zeros leave one symbol of budget, A1 still ends the run
    go(1'b1);
    send(1'b0, 8'h00);
    for (int i = 0; i < 39; i++) send(1'b0, 8'h00);
    for (int i = 0; i < 3; i++) send(1'b1, 8'hA1);
    send(1'b0, 8'hFB);
    outs("R5 mfm 39 zeros", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);

    // R5: 40 zeros exhaust the budget, so three more syncs are needed
    go(1'b1);
    send(1'b0, 8'h00);
    for (int i = 0; i < 40; i++) send(1'b0, 8'h00);
    send(1'b1, 8'hA1);
    send(1'b1, 8'hA1);
    send(1'b0, 8'hFB);
    outs("R5 mfm 40 zeros", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

    // R5: FM gap budget of 30, then a flagged mark directly
    go(1'b0);
    for (int i = 0; i < 29; i++) send(1'b0, 8'hFF);
    outs("R5 fm gap 29", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send(1'b0, 8'hFF);
    outs("R5 fm gap 30", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    send(1'b1, 8'hF8);
    outs("R5 fm exhaust mark", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    chk8("R5 fm exhaust mark", "crc_byte", crc_byte, 8'hF8);

    // R5: FM exhausted, a zero is no longer accepted
    go(1'b0);
    for (int i = 0; i < 30; i++) send(1'b0, 8'hFF);
    send(1'b0, 8'h00);
    outs("R5 fm exhaust zero", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);

    // R2: start during a search is ignored, MFM kept
    go(1'b1);
    send(1'b0, 8'h00);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    chk1("R2 restart", "busy", busy, 1'b1);
    for (int i = 0; i < 3; i++) send(1'b1, 8'hA1);
    send(1'b0, 8'hFB);
    outs("R2 restart ignored", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);

    // R1: reset in mid search returns to idle, symbols then ignored
    go(1'b1);
    send(1'b0, 8'h00);
    send(1'b1, 8'hA1);
    @(negedge clk) rst_n = 1'b0;
    #1;
    outs("R1 reset mid", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    send(1'b1, 8'hA1);
    send(1'b0, 8'hFB);
    outs("R1 idle after reset", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule